// File: doc/BRIEF.md
# Compare-Match Microsecond Timer

This peripheral keeps a 64-bit counter that advances once per microsecond from the moment reset is released. A prescaler divides the system clock down to that rate. Four compare channels each hold a 32-bit target value. When the low half of the counter steps onto a channel's target, that channel sets a sticky status flag and raises its own interrupt line. Because only the low 32 bits take part in the match, a given target fires again every 2^32 microseconds.

Software reaches the block over a small 32-bit register bus with a decoded window of 0x20 bytes. Software arms a channel by writing a target value. It acknowledges the interrupt by writing a one to the channel's status bit. To read the counter, software reads the low word first. That read freezes the high word in a shadow register, so the high-word read that follows belongs to the same 64-bit sample. Read data comes back one cycle after the request.

Top module: `cmp_timer`

## Requirements
- R1: After reset the counter is zero, and it increases by exactly one every CLK_MHZ clock cycles.
- R2: A read at offset 0x04 returns the counter's low word as it stood in the request cycle. A read at offset 0x08 returns the high word captured by the most recent low-word read, or zero if no low-word read has happened since reset. Read data appears on rdata_o one cycle after the request and holds until the next read.
- R3: The counter words at 0x04 and 0x08 are read-only, and writes to them leave the count unchanged.
- R4: Compare channel n sits at offset 0x0C + 4n. On the tick where the counter's low word becomes equal to channel n's compare value, status bit n (bit n at offset 0x00) is set and irq_o[n] is raised in that same clock cycle.
- R5: A status bit and its interrupt line stay set while the counter moves on past the compare value, until software clears them.
- R6: A write to offset 0x00 clears each status bit whose written bit is one and drops the matching interrupt line. Bits written as zero leave their channel unchanged.
- R7: If a match and a software clear hit the same channel in the same cycle, the channel stays set.
- R8: Compare registers are read/write, and a read returns the last value written.
- R9: Reset clears the status bits, all interrupt lines and all compare registers to zero.
- R10: A read at offset 0x1C, or at any address with bits [1:0] non-zero, returns zero. A write to such an address changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, CLK_MHZ MHz |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request for this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Byte offset inside the 0x20 window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| irq_o | output | NUM_CH | Per-channel interrupt, equal to the status bits |

## Verification
The bench aims a match at a known tick and checks the interrupt on the cycle just before the tick and on the cycle it lands. A design that compared the old counter value would fire one tick late and fail here. It then places a status clear on exactly the clock edge where the same channel matches again. A design that let the clear win would drop an interrupt that should stay up. The bench also checks that writing zeros, or writing other channels' bits, leaves a pending channel alone. Two channels are aimed at the same tick so that both must fire together. Writes to the counter words, to the unmapped slot and to misaligned addresses are each followed by a read-back of the registers they could have corrupted.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 32;

  // word slots, addr_i[4:2]
  localparam logic [2:0] SLOT_STAT = 3'd0;
  localparam logic [2:0] SLOT_LO   = 3'd1;
  localparam logic [2:0] SLOT_HI   = 3'd2;
  localparam int unsigned CH_BASE  = 3;
endpackage

// File: rtl/cmp_timer_prescale.sv
module cmp_timer_prescale #(
  parameter int unsigned DIV = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            div_q <= '0;
    else if (div_q == LAST) div_q <= '0;
    else                    div_q <= div_q + 1'b1;
  end

  assign tick_o = (div_q == LAST);
endmodule

// File: rtl/cmp_timer_counter.sv
module cmp_timer_counter #(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned LO_W  = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [LO_W-1:0]  nxt_lo_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o    = cnt_q;
  // low word value after the pending tick, used for match detection
  assign nxt_lo_o = cnt_q[LO_W-1:0] + 1'b1;
endmodule

// File: rtl/cmp_timer_channel.sv
module cmp_timer_channel #(
  parameter int unsigned CMP_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CMP_W-1:0] nxt_lo_i,
  input  logic             cmp_we_i,
  input  logic [CMP_W-1:0] wdata_i,
  input  logic             clr_i,
  output logic [CMP_W-1:0] cmp_o,
  output logic             flag_o
);
  logic [CMP_W-1:0] cmp_q;
  logic             flag_q;
  logic             hit;

  assign hit = tick_i && (nxt_lo_i == cmp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cmp_q <= '0;
    else if (cmp_we_i) cmp_q <= wdata_i;
  end

  // match has priority over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (hit)   flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign cmp_o  = cmp_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int unsigned CLK_MHZ = 100,
  parameter int unsigned NUM_CH  = 4,
  parameter int unsigned CNT_W   = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NUM_CH-1:0] irq_o
);
  localparam int unsigned HI_W = CNT_W - DATA_W;

  logic              tick;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] nxt_lo;
  logic [HI_W-1:0]   shadow_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rd_nxt;
  logic [NUM_CH-1:0] flags;
  logic [NUM_CH-1:0] clr;
  logic [NUM_CH-1:0] cmp_we;
  logic [DATA_W-1:0] cmp_val [NUM_CH];
  logic [2:0]        slot;
  logic              aligned;
  logic              wr_ok;
  logic              rd_ok;

  assign slot    = addr_i[4:2];
  assign aligned = (addr_i[1:0] == 2'b00);
  assign wr_ok   = req_i && we_i && aligned;
  assign rd_ok   = req_i && !we_i;

  cmp_timer_prescale #(.DIV(CLK_MHZ)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  cmp_timer_counter #(.CNT_W(CNT_W), .LO_W(DATA_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .cnt_o    (cnt_q),
    .nxt_lo_o (nxt_lo)
  );

  assign clr = (wr_ok && slot == SLOT_STAT) ? wdata_i[NUM_CH-1:0] : '0;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    assign cmp_we[n] = wr_ok && (slot == 3'(CH_BASE + n));

    cmp_timer_channel #(.CMP_W(DATA_W)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick),
      .nxt_lo_i (nxt_lo),
      .cmp_we_i (cmp_we[n]),
      .wdata_i  (wdata_i),
      .clr_i    (clr[n]),
      .cmp_o    (cmp_val[n]),
      .flag_o   (flags[n])
    );
  end

  always_comb begin
    rd_nxt = '0;
    if (aligned) begin
      case (slot)
        SLOT_STAT: rd_nxt = DATA_W'(flags);
        SLOT_LO:   rd_nxt = cnt_q[DATA_W-1:0];
        SLOT_HI:   rd_nxt = DATA_W'(shadow_q);
        default: begin
          for (int n = 0; n < NUM_CH; n++) begin
            if (slot == 3'(CH_BASE + n)) rd_nxt = cmp_val[n];
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_q <= '0;
    else if (rd_ok) rdata_q <= rd_nxt;
  end

  // low-word read freezes the high word for a coherent 64-bit sample
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                shadow_q <= '0;
    else if (rd_ok && aligned && slot == SLOT_LO) shadow_q <= cnt_q[CNT_W-1:DATA_W];
  end

  assign rdata_o = rdata_q;
  assign irq_o   = flags;
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CNT_W  = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [4:0]        addr_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic [NUM_CH-1:0] irq_o,
  input logic              tick_i,
  input logic [CNT_W-1:0]  cnt_i
);
  assert_cnt_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> cnt_i == $past(cnt_i) + CNT_W'(1));

  assert_cnt_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_i));

  assert_unmapped_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i[4:2] == 3'd7) |=> rdata_o == 32'd0);

  for (genvar n = 0; n < NUM_CH; n++) begin : g_a
    assert_irq_on_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_o[n]) |-> $past(tick_i));

    assert_irq_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_o[n] && !(req_i && we_i && addr_i == 5'h00 && wdata_i[n])) |=> irq_o[n]);

    assert_irq_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && we_i && addr_i == 5'h00 && wdata_i[n] && !tick_i) |=> !irq_o[n]);
  end
endmodule

bind cmp_timer cmp_timer_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .tick_i  (tick),
  .cnt_i   (cnt_q)
);

// File: tb/cmp_timer_tb.sv
module cmp_timer_tb;
  localparam int unsigned MHZ = 4;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } rd_item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  rd_item_t    rd_q[$];
  logic        rd_seen = 1'b0;
  logic [63:0] cnt_m;
  int          div_m;

  always #5 clk = ~clk;

  cmp_timer #(.CLK_MHZ(MHZ), .NUM_CH(4), .CNT_W(64)) u_dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .req_i   (req),
    .we_i    (we),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .irq_o   (irq)
  );

  // microsecond reference: one step every MHZ clocks
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_m <= 0;
      cnt_m <= '0;
    end else if (div_m == MHZ - 1) begin
      div_m <= 0;
      cnt_m <= cnt_m + 64'd1;
    end else begin
      div_m <= div_m + 1;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  // monitor: scoreboard side
  always @(posedge clk) rd_seen <= rst_n && req && !we;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (rd_q.size() == 0) begin
        chk("scoreboard underflow", 32'd1, 32'd0);
      end else begin
        rd_item_t it;
        it = rd_q.pop_front();
        chk(it.tag, rdata, it.exp);
      end
    end
  end

  task automatic bus_wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(logic [4:0] a, logic [31:0] exp, bit want_lo, string tag);
    rd_item_t it;
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    it.exp = want_lo ? cnt_m[31:0] : exp;
    it.tag = tag;
    rd_q.push_back(it);
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_cnt(logic [63:0] v);
    while (cnt_m < v) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [63:0] c;
    logic [63:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state
    chk("R9 irq after reset", 32'(irq), 32'd0);
    bus_rd(5'h00, 32'd0, 0, "R9 status reset");
    for (int n = 0; n < 4; n++) bus_rd(5'(12 + 4 * n), 32'd0, 0, "R9 compare reset");

    // R1 / R2 counter reads at several points
    bus_rd(5'h04, 32'd0, 1, "R1 counter low");
    bus_rd(5'h08, 32'd0, 0, "R2 shadow high");
    repeat (13) @(negedge clk);
    bus_rd(5'h04, 32'd0, 1, "R1 counter low later");
    repeat (7) @(negedge clk);
    bus_rd(5'h04, 32'd0, 1, "R2 counter low again");
    bus_rd(5'h08, 32'd0, 0, "R2 high after low");

    // R3 counter is read-only
    bus_wr(5'h04, 32'hFFFF_FFFF);
    bus_wr(5'h08, 32'h0000_1234);
    bus_rd(5'h04, 32'd0, 1, "R3 low after write");
    bus_rd(5'h08, 32'd0, 0, "R3 high after write");

    // R8 compare read/write
    for (int n = 0; n < 4; n++) bus_wr(5'(12 + 4 * n), 32'hA5A5_0000 + 32'(n * 17));
    for (int n = 0; n < 4; n++) bus_rd(5'(12 + 4 * n), 32'hA5A5_0000 + 32'(n * 17), 0, "R8 compare readback");

    // R10 unmapped and misaligned
    bus_rd(5'h1C, 32'd0, 0, "R10 unmapped read");
    bus_wr(5'h1C, 32'hDEAD_BEEF);
    bus_rd(5'h18, 32'hA5A5_0000 + 32'd51, 0, "R10 C3 after unmapped write");
    bus_rd(5'h0D, 32'd0, 0, "R10 misaligned read");
    bus_wr(5'h0E, 32'h1111_2222);
    bus_rd(5'h0C, 32'hA5A5_0000, 0, "R10 C0 after misaligned write");

    // R4 match timing on channel 0
    c = cnt_m;
    bus_wr(5'h0C, c[31:0] + 32'd6);
    wait_cnt(c + 5);
    chk("R4 no irq before match", 32'(irq), 32'd0);
    wait_cnt(c + 6);
    chk("R4 irq on match tick", 32'(irq), 32'h1);
    bus_rd(5'h00, 32'h1, 0, "R4 status bit 0");

    // R5 sticky
    wait_cnt(c + 10);
    chk("R5 irq still set", 32'(irq), 32'h1);

    // R6 clear
    bus_wr(5'h00, 32'h0);
    chk("R6 zero write keeps irq", 32'(irq), 32'h1);
    bus_wr(5'h00, 32'hE);
    chk("R6 other bits keep irq0", 32'(irq), 32'h1);
    bus_wr(5'h00, 32'h1);
    chk("R6 clear drops irq0", 32'(irq), 32'h0);
    bus_rd(5'h00, 32'h0, 0, "R6 status cleared");

    // R4 two channels on the same tick
    c = cnt_m;
    bus_wr(5'h14, c[31:0] + 32'd6);
    bus_wr(5'h18, c[31:0] + 32'd6);
    wait_cnt(c + 6);
    chk("R4 dual match", 32'(irq), 32'hC);
    bus_rd(5'h00, 32'hC, 0, "R4 dual status");
    bus_wr(5'h00, 32'h4);
    chk("R6 partial clear", 32'(irq), 32'h8);
    bus_wr(5'h00, 32'h8);
    chk("R6 clear ch3", 32'(irq), 32'h0);

    // R7 match vs clear in the same cycle
    c = cnt_m;
    bus_wr(5'h10, c[31:0] + 32'd4);
    wait_cnt(c + 4);
    chk("R7 setup ch1 set", 32'(irq), 32'h2);
    d = cnt_m + 64'd4;
    bus_wr(5'h10, d[31:0]);
    while (!(cnt_m == d - 64'd1 && div_m == MHZ - 1)) @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 5'h00; wdata = 32'h2;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    chk("R7 tick count aligned", cnt_m[31:0], d[31:0]);
    chk("R7 match beats clear", 32'(irq), 32'h2);
    bus_wr(5'h00, 32'h2);
    chk("R7 later clear works", 32'(irq), 32'h0);

    repeat (4) @(negedge clk);
    chk("R2 scoreboard drained", 32'(rd_q.size()), 32'd0);
    finish_run();
  end
endmodule